// File: doc/BRIEF.md
# Sixteen-Bit Adder/Subtractor with Two-Level Carry Lookahead

This block adds or subtracts two 16-bit operands without rippling a carry from one 4-bit slice to the next. The word is split into four identical 4-bit slices. Bits 3:0 go to slice 0, bits 7:4 to slice 1, bits 11:8 to slice 2 and bits 15:12 to slice 3. All slices share one 3-bit operation select. Each slice reports two group terms instead of a carry out. The generate term is set when the slice carries out of its top bit with a carry-in of 0. The propagate term is set when the slice carries out of its top bit with a carry-in of 1.

A separate lookahead network turns the four generate/propagate pairs and the global carry-in into the carry-ins of slices 1, 2 and 3. The network has no carry out of bit 16. Instead it presents a block generate and a block propagate, so that a higher lookahead level can treat the whole unit as one group. The unit is purely combinational.

Top module: `cla_alu16`

## Requirements
- R1: With `op` = 3'b000, `res` equals the low 16 bits of `x + y + ci`.
- R2: With `op` = 3'b001, `res` equals the low 16 bits of `x - y`. This is computed as `x + ~y + 1`, and `ci` has no effect.
- R3: A carry produced in one slice reaches the slices above it through the lookahead network. Examples are 16'h000F + 1, 16'h00FF + 1, 16'h0FFF + 1 and 16'hFFFF + 1.
- R4: `grp_g` equals the carry out of bit 15 of `x + y_eff` with a forced carry-in of 0. Here `y_eff` is `y` for add and `~y` for subtract.
- R5: `grp_g | grp_p` equals the carry out of bit 15 of `x + y_eff + 1`. The rebuilt carry out `grp_g | (grp_p & c0)` equals bit 16 of the full 17-bit result, where c0 is `ci` for add and 1 for subtract.
- R6: Every `op` value other than 3'b001 performs the add of R1.
- R7: With all inputs at zero, `res`, `grp_g` and `grp_p` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 16 | First operand |
| y | input | 16 | Second operand |
| op | input | 3 | Operation select: 001 subtract, any other value add |
| ci | input | 1 | Global carry-in (ignored on subtract) |
| res | output | 16 | Result |
| grp_g | output | 1 | Block carry generate |
| grp_p | output | 1 | Block carry propagate |

## Verification
The in-RTL assertions are immediate checks. They assume the inputs are two-state and settled whenever the combinational logic is evaluated. They treat any `op` code other than 001 as an add. The bench changes inputs only on the falling clock edge and compares outputs on the rising edge, so every comparison sees settled values. The stimulus covers every `op` code, both values of `ci`, carry chains that stop at and cross each slice boundary, and random operands.

// File: rtl/cla_alu16.sv
module cla_nibble #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] f,
  output logic         g,
  output logic         p
);
  logic [W-1:0] be;
  assign be = sub ? ~b : b;
  assign f  = a + be + {{(W-1){1'b0}}, cin};
  assign g  = ({1'b0, a} + {1'b0, be}) > {1'b0, {W{1'b1}}};
  assign p  = ({1'b0, a} + {1'b0, be} + {{W{1'b0}}, 1'b1}) > {1'b0, {W{1'b1}}};

  always_comb begin
    a_r5_gen_implies_prop: assert (!g || p)
      else $error("slice generate without propagate");
  end
endmodule

module cla_net #(
  parameter int N = 4
) (
  input  logic [N-1:0] g,
  input  logic [N-1:0] p,
  input  logic         c0,
  output logic [N-1:0] c,
  output logic         bg,
  output logic         bp
);
  logic [N:0] cc;
  assign cc[0] = c0;
  for (genvar i = 1; i <= N; i++) begin : g_carry
    always_comb begin
      cc[i] = c0 & (&p[i-1:0]);
      for (int j = 0; j < i; j++) begin
        logic t;
        t = g[j];
        for (int k = j + 1; k < i; k++) t = t & p[k];
        cc[i] = cc[i] | t;
      end
    end
  end
  assign c = cc[N-1:0];

  always_comb begin
    bg = 1'b0;
    for (int j = 0; j < N; j++) begin
      logic t;
      t = g[j];
      for (int k = j + 1; k < N; k++) t = t & p[k];
      bg = bg | t;
    end
  end
  assign bp = &p;

  always_comb begin
    a_r3_no_prop_c1: assert (p[0] || (cc[1] == g[0]))
      else $error("carry into slice 1 wrong when slice 0 cannot propagate");
    a_r3_full_prop_top: assert (!(&p[N-2:0]) || g[N-2] || (cc[N-1] == (c0 | (|g[N-2:0]))))
      else $error("carry into top slice wrong with all lower slices propagating");
  end
  wire unused_cc = cc[N];
endmodule

module cla_alu16 (
  input  logic [15:0] x,
  input  logic [15:0] y,
  input  logic [2:0]  op,
  input  logic        ci,
  output logic [15:0] res,
  output logic        grp_g,
  output logic        grp_p
);
  localparam int W  = 16;
  localparam int SW = 4;
  localparam int NS = W / SW;

  logic          sub, c0;
  logic [NS-1:0] sg, sp, sc;

  assign sub = (op == 3'b001);
  assign c0  = sub | ci;

  for (genvar i = 0; i < NS; i++) begin : g_slice
    cla_nibble #(.W(SW)) u_sl (
      .a(x[i*SW +: SW]), .b(y[i*SW +: SW]), .sub(sub), .cin(sc[i]),
      .f(res[i*SW +: SW]), .g(sg[i]), .p(sp[i]));
  end

  cla_net #(.N(NS)) u_net (.g(sg), .p(sp), .c0(c0), .c(sc), .bg(grp_g), .bp(grp_p));

  logic [W:0] ref_sum;
  assign ref_sum = {1'b0, x} + {1'b0, (sub ? ~y : y)} + {{W{1'b0}}, c0};

  always_comb begin
    a_r1_add_result: assert (sub || res == ref_sum[W-1:0])
      else $error("add result mismatch");
    a_r2_sub_result: assert (!sub || res == x - y)
      else $error("subtract result mismatch");
    a_r5_carry_rebuild: assert ((grp_g | (grp_p & c0)) == ref_sum[W])
      else $error("rebuilt carry out mismatch");
    a_r4_bg_slice_equiv: assert (!(&sp) || grp_g == ((|sg) & grp_g))
      else $error("block generate inconsistent");
  end
endmodule

// File: tb/tb_cla_alu16.sv
module tb_cla_alu16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [15:0] x, y, res;
  logic [2:0]  op;
  logic        ci, grp_g, grp_p;

  cla_alu16 dut (.x(x), .y(y), .op(op), .ci(ci), .res(res), .grp_g(grp_g), .grp_p(grp_p));

  typedef struct {
    logic [15:0] f;
    logic        g, gp, co;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic drive(input logic [15:0] a, input logic [15:0] b,
                       input logic [2:0] o, input logic c, input string tag);
    item_t it;
    logic [15:0] be;
    logic        c0;
    logic [16:0] s0, s1, s;
    @(negedge clk);
    x = a; y = b; op = o; ci = c;
    be = (o == 3'b001) ? ~b : b;
    c0 = (o == 3'b001) ? 1'b1 : c;
    s0 = {1'b0, a} + {1'b0, be};
    s1 = s0 + 17'd1;
    s  = c0 ? s1 : s0;
    it.f = s[15:0]; it.g = s0[16]; it.gp = s1[16]; it.co = s[16]; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      cmp(it.tag, "res", int'(res), int'(it.f));
      cmp("R4", "grp_g", int'(grp_g), int'(it.g));
      cmp("R5", "grp_g|grp_p", int'(grp_g | grp_p), int'(it.gp));
      cmp("R5", "rebuilt_co", int'(grp_g | (grp_p & ((op == 3'b001) | ci))), int'(it.co));
    end
  end

  initial begin
    x = '0; y = '0; op = '0; ci = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if (res !== 16'h0 || grp_g !== 1'b0 || grp_p !== 1'b0) begin
      fails++;
      $display("FAIL R7 zero inputs actual=%0h/%0b/%0b expected=0/0/0", res, grp_g, grp_p);
    end
    drive(16'h0000, 16'h0000, 3'b000, 1'b0, "R7");
    drive(16'h1234, 16'h4321, 3'b000, 1'b0, "R1");
    drive(16'h1234, 16'h4321, 3'b000, 1'b1, "R1");
    drive(16'hFFFF, 16'h0001, 3'b000, 1'b0, "R1");
    drive(16'h000F, 16'h0001, 3'b000, 1'b0, "R3");
    drive(16'h00FF, 16'h0001, 3'b000, 1'b0, "R3");
    drive(16'h0FFF, 16'h0001, 3'b000, 1'b0, "R3");
    drive(16'hFFFF, 16'h0000, 3'b000, 1'b1, "R3");
    drive(16'h0F0F, 16'h00F1, 3'b000, 1'b0, "R3");
    drive(16'h8000, 16'h8000, 3'b000, 1'b0, "R4");
    drive(16'h5000, 16'h0001, 3'b001, 1'b0, "R2");
    drive(16'h5000, 16'h0001, 3'b001, 1'b1, "R2");
    drive(16'h0000, 16'h0001, 3'b001, 1'b0, "R2");
    drive(16'h1234, 16'h1234, 3'b001, 1'b0, "R2");
    for (int o = 2; o < 8; o++) begin
      drive(16'hABCD, 16'h5433, 3'(o), 1'b1, "R6");
      drive(16'h0FFF, 16'h0001, 3'(o), 1'b0, "R6");
    end
    for (int i = 0; i < 400; i++)
      drive(16'($urandom), 16'($urandom), ($urandom % 2 == 0) ? 3'b000 : 3'b001,
            1'($urandom), (i % 2 == 0) ? "R1" : "R2");
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    for (int n = 0; n < 200000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule